// File: doc/BRIEF.md
# Asynchronous DRAM cycle sequencer

This block turns host requests into pin sequences for an asynchronous 4M x 4 DRAM. The host side is a request/acknowledge port. It carries a 22-bit word address, 4-bit write data, a write flag and a read-modify-write flag. The memory side drives the row strobe, column strobe, write enable, output enable, a 12-bit multiplexed address bus and a data output with its own enable. The 4-bit read data comes back on a separate input.

The block has no mode register. The memory tells the cycle types apart by the order of the pin edges:
- Write enable low before the column strobe falls selects a write.
- Write enable falling while the column strobe is already low selects read-modify-write.
- Column strobe falling while the row strobe is still high selects a refresh.

Every interval is a count of system clocks. Each count is derived from a nanosecond parameter as ceil(ns / clock period), with a minimum of one clock. A separate refresh request input starts a column-before-row refresh. Refresh is considered only between cycles.

Top module: `dram_seq`

## Requirements
- R1: While reset is held, and after it is released with no request pending, the row strobe, column strobe, write enable and output enable are all high. The data output enable is 0, and ack and ref_done are 0.
- R2: A read (rmw=0, we=0) works as follows. The row strobe falls, and the column strobe falls at least ceil(20 ns/period) clocks later. Write enable stays high and output enable is low while the column strobe is low. The data on dq_in is loaded into rdata, and ack is a single-clock pulse in the same cycle that rdata takes the new value.
- R3: The word address is split into row = addr[21:10] and column = addr[9:0]. The row is on ma when the row strobe falls and is held for at least ceil(10 ns/period) clocks. At the column strobe fall, ma holds {2'b00, column}.
- R4: A write (rmw=0, we=1) pulls write enable low at least one clock before the column strobe falls. The data output is enabled at the moment the column strobe falls.
- R5: A read-modify-write (rmw=1) proceeds in four steps:
  1. It reads with output enable low and returns the old word on rdata.
  2. It raises output enable.
  3. It pulls write enable low at least ceil(46 ns/period) clocks after the column strobe fell.
  4. It stores the new word.
- R6: A refresh pulls the column strobe low at least ceil(5 ns/period) clocks before the row strobe falls, with write enable high. It keeps the column strobe low for at least ceil(10 ns/period) clocks after the row strobe falls. It ends with a single-clock ref_done pulse.
- R7: The row strobe meets three limits:
  - It stays low for at least ceil(70 ns/period) clocks.
  - It stays high for at least ceil(50 ns/period) clocks before it falls again.
  - Successive falls are at least ceil(130 ns/period) clocks apart, or ceil(181 ns/period) clocks after a read-modify-write.
- R8: When both are waiting at a cycle boundary, a refresh request wins over a host request. A refresh request that arrives during a host cycle waits until that cycle has finished.
- R9: The data output is never enabled while output enable is low.
- R10: Cycle type encoding: rmw=1 selects read-modify-write whatever the value of we. Otherwise we=1 selects a write and we=0 selects a read.

Timing limits apply to the fastest speed grade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | Host write flag |
| rmw | input | 1 | Host read-modify-write flag |
| addr | input | 22 | Host word address |
| wdata | input | 4 | Host write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 4 | Captured read data |
| ref_req | input | 1 | Refresh request, held until ref_done |
| ref_done | output | 1 | One-clock refresh completion pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ma | output | 12 | Multiplexed row/column address |
| dq_out | output | 4 | Data toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 4 | Data from the memory |

## Verification
The bench connects a memory model. The model classifies each cycle purely from edge order, latches the row and column from ma, and measures every strobe spacing in clocks.

The stimulus patterns and what each one exposes:
- **Opposite corners of the address space.** Writes and reads at these addresses catch a wrong row/column split.
- **A row-boundary address next to an unwritten address.** This exposes aliasing between the address halves.
- **A read-modify-write.** It must return the old word and leave the new one, which separates it from a plain read or a plain write.
- **A request with rmw=1 and we=1.** It shows which flag wins.
- **Refresh raised together with a host request.** This shows the priority order.
- **Refresh raised in the middle of a read.** This shows that a cycle is never cut short.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int CLK_NS = 5,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 4,
  parameter int CNT_W  = 8,
  parameter int RC_NS  = 130,
  parameter int RWC_NS = 181,
  parameter int RAS_NS = 70,
  parameter int RP_NS  = 50,
  parameter int CAS_NS = 18,
  parameter int RCD_NS = 20,
  parameter int RAH_NS = 10,
  parameter int CAH_NS = 15,
  parameter int RAC_NS = 70,
  parameter int CAC_NS = 18,
  parameter int CWD_NS = 46,
  parameter int RWD_NS = 98,
  parameter int OED_NS = 18,
  parameter int CWL_NS = 18,
  parameter int WP_NS  = 10,
  parameter int CSR_NS = 5,
  parameter int CHR_NS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic                   rmw,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DQ_W-1:0]        wdata,
  output logic                   ack,
  output logic [DQ_W-1:0]        rdata,
  input  logic                   ref_req,
  output logic                   ref_done,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [ROW_W-1:0]       ma,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe,
  input  logic [DQ_W-1:0]        dq_in
);

  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RAH     = cyc(RAH_NS);
  localparam int L_COLS    = mx(cyc(RCD_NS) - T_RAH, 1);
  localparam int T_RCD     = T_RAH + L_COLS;
  localparam int T_RAS     = cyc(RAS_NS);
  localparam int L_CAS     = mx(mx(cyc(CAS_NS), cyc(CAC_NS)),
                                mx(cyc(CAH_NS), mx(T_RAS, cyc(RAC_NS)) - T_RCD));
  localparam int L_OED     = cyc(OED_NS);
  localparam int L_WRL     = mx(cyc(CWL_NS), cyc(WP_NS));
  localparam int L_RMWRD   = mx(mx(mx(cyc(CAC_NS), cyc(RAC_NS) - T_RCD), cyc(CWD_NS) - L_OED),
                                mx(cyc(RWD_NS) - T_RCD - L_OED, T_RAS - T_RCD - L_OED - L_WRL));
  localparam int L_PRE_RW  = mx(cyc(RP_NS), cyc(RC_NS) - T_RCD - L_CAS - 2);
  localparam int L_PRE_RMW = mx(cyc(RP_NS), cyc(RWC_NS) - T_RCD - L_RMWRD - L_OED - L_WRL - 2);
  localparam int L_CSR     = cyc(CSR_NS);
  localparam int L_CHR     = cyc(CHR_NS);
  localparam int L_CBRH    = mx(T_RAS - L_CHR, 1);
  localparam int L_PRE_CBR = mx(cyc(RP_NS), cyc(RC_NS) - L_CHR - L_CBRH - 2);

  typedef enum logic [3:0] {
    S_IDLE, S_ROWS, S_ROWH, S_COLS, S_CASL, S_OED, S_WRL, S_PRE, S_CBRC, S_CBRR, S_CBRH
  } st_t;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_RMW} op_t;

  st_t              state, nxt;
  op_t              op;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DQ_W-1:0]  wd_q;
  logic             adv;
  int               len;

  always_comb begin
    nxt = state;
    len = 1;
    adv = (state == S_IDLE) ? (ref_req | req) : (cnt == '0);
    case (state)
      S_IDLE: begin nxt = ref_req ? S_CBRC : S_ROWS; len = ref_req ? L_CSR : 1; end
      S_ROWS: begin nxt = S_ROWH; len = T_RAH; end
      S_ROWH: begin nxt = S_COLS; len = L_COLS; end
      S_COLS: begin nxt = S_CASL; len = (op == OP_RMW) ? L_RMWRD : L_CAS; end
      S_CASL: begin nxt = (op == OP_RMW) ? S_OED : S_PRE; len = (op == OP_RMW) ? L_OED : L_PRE_RW; end
      S_OED:  begin nxt = S_WRL; len = L_WRL; end
      S_WRL:  begin nxt = S_PRE; len = L_PRE_RMW; end
      S_PRE:  begin nxt = S_IDLE; len = 1; end
      S_CBRC: begin nxt = S_CBRR; len = L_CHR; end
      S_CBRR: begin nxt = S_CBRH; len = L_CBRH; end
      S_CBRH: begin nxt = S_PRE; len = L_PRE_CBR; end
      default: begin nxt = S_IDLE; len = 1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      op       <= OP_RD;
      row_q    <= '0;
      col_q    <= '0;
      wd_q     <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
      ref_done <= 1'b0;
    end else begin
      ack      <= 1'b0;
      ref_done <= adv && state == S_CBRH;
      if (adv) begin
        state <= nxt;
        cnt   <= CNT_W'(len - 1);
      end else if (state != S_IDLE) begin
        cnt <= cnt - 1'b1;
      end
      if (adv && state == S_IDLE && !ref_req) begin
        op    <= rmw ? OP_RMW : (we ? OP_WR : OP_RD);
        row_q <= addr[ROW_W+COL_W-1:COL_W];
        col_q <= addr[COL_W-1:0];
        wd_q  <= wdata;
      end
      if (adv && state == S_CASL) begin
        if (op != OP_WR)  rdata <= dq_in;
        if (op != OP_RMW) ack   <= 1'b1;
      end
      if (adv && state == S_WRL) ack <= 1'b1;
    end
  end

  wire early_wr = (op == OP_WR) && (state == S_COLS || state == S_CASL);

  assign ras_n  = !(state inside {S_ROWH, S_COLS, S_CASL, S_OED, S_WRL, S_CBRR, S_CBRH});
  assign cas_n  = !(state inside {S_CASL, S_OED, S_WRL, S_CBRC, S_CBRR});
  assign we_n   = !(early_wr || state == S_WRL);
  assign oe_n   = !(op != OP_WR && state == S_CASL);
  assign dq_oe  = early_wr || state == S_WRL;
  assign dq_out = wd_q;
  assign ma     = (state == S_ROWS || state == S_ROWH) ? row_q : ROW_W'(col_q);

  logic [CNT_W-1:0] ras_lo;
  always_ff @(posedge clk) begin
    if (!rst_n)      ras_lo <= '0;
    else if (!ras_n) ras_lo <= ras_lo + 1'b1;
    else             ras_lo <= '0;
  end

  AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R2
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RAH > 1) && $fell(ras_n) |=> $stable(ma)); // R3
  AST_REF_W_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (we_n && oe_n)); // R6
  AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ras_lo >= CNT_W'(T_RAS)); // R7
  AST_REF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && ras_n |-> $past(ras_n) && $past(cas_n)); // R8
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R9

endmodule

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, rmw = 0, ref_req = 0;
  logic [21:0] addr = '0;
  logic [3:0] wdata = '0, dq_in = '0;
  logic ack, ref_done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rdata, dq_out;
  logic [11:0] ma;

  always #2.5 clk = ~clk;

  dram_seq u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .rmw(rmw), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .ref_req(ref_req), .ref_done(ref_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .ma(ma), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in));

  localparam int P = 5;
  localparam int K_RAS = (70 + P - 1) / P, K_RP = (50 + P - 1) / P, K_RC = (130 + P - 1) / P;
  localparam int K_RWC = (181 + P - 1) / P, K_RCD = (20 + P - 1) / P, K_RAH = (10 + P - 1) / P;
  localparam int K_CSR = (5 + P - 1) / P, K_CHR = (10 + P - 1) / P, K_CWD = (46 + P - 1) / P;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  logic [3:0] mem [logic [21:0]];
  logic [21:0] cur_addr = '0;
  logic [11:0] row_m = '0;
  logic [9:0] col_m = '0;
  int cyc = 0, t_rf = -100, t_rr = -100, t_cf = -100, t_cr = -100, t_wf = -100;
  int kind = -1, kind_at_rise = -1, cbr_cnt = 0;
  bit has_prev = 0, track = 0, first_cbr = 0, cbr_now = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;

  function automatic logic [3:0] rd_mem(input logic [21:0] k);
    return mem.exists(k) ? mem[k] : 4'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dq_oe) chk(oe_n, "R9 drive while OE low", oe_n, 1);
      if (!we_n && p_we) t_wf = cyc;
      if (!cas_n && p_cas && ras_n) begin
        chk(we_n, "R6 W high at refresh start", we_n, 1);
        t_cf = cyc; kind = 3;
      end
      if (!ras_n && p_ras) begin
        if (has_prev)
          chk(cyc - t_rf >= ((kind_at_rise == 2) ? K_RWC : K_RC), "R7 fall-to-fall", cyc - t_rf,
              (kind_at_rise == 2) ? K_RWC : K_RC);
        chk(cyc - t_rr >= K_RP, "R7 precharge", cyc - t_rr, K_RP);
        cbr_now = !cas_n;
        if (track) begin first_cbr = cbr_now; track = 0; end
        if (cbr_now) begin
          chk(cyc - t_cf >= K_CSR, "R6 CAS before RAS", cyc - t_cf, K_CSR);
          cbr_cnt++;
        end else begin
          chk(ma == cur_addr[21:10], "R3 row at RAS fall", ma, cur_addr[21:10]);
          row_m = ma;
        end
        t_rf = cyc; has_prev = 1;
      end
      if (!ras_n && !cbr_now && cyc - t_rf == K_RAH - 1)
        chk(ma == cur_addr[21:10], "R3 row hold", ma, cur_addr[21:10]);
      if (!cas_n && p_cas && !ras_n) begin
        t_cf = cyc;
        chk(cyc - t_rf >= K_RCD, "R2 RAS to CAS", cyc - t_rf, K_RCD);
        chk(ma == {2'b00, cur_addr[9:0]}, "R3 column at CAS fall", ma, {2'b00, cur_addr[9:0]});
        col_m = ma[9:0];
        if (!we_n) begin
          kind = 1;
          chk(t_wf < cyc, "R4 W before CAS", t_wf, cyc - 1);
          chk(dq_oe, "R4 data driven at CAS fall", dq_oe, 1);
          mem[{row_m, col_m}] = dq_out;
        end else begin
          kind = 0;
          chk(!oe_n, "R2 OE low in read", oe_n, 0);
        end
      end
      if (!we_n && p_we && !cas_n && !ras_n && p_cas == 1'b0) begin
        kind = 2;
        chk(cyc - t_cf >= K_CWD, "R5 CAS to W delay", cyc - t_cf, K_CWD);
        chk(oe_n, "R5 OE high before W", oe_n, 1);
        mem[{row_m, col_m}] = dq_out;
      end
      if (cas_n && !p_cas) t_cr = cyc;
      if (ras_n && !p_ras) begin
        chk(cyc - t_rf >= K_RAS, "R7 RAS low time", cyc - t_rf, K_RAS);
        if (cbr_now) chk(t_cr - t_rf >= K_CHR, "R6 CAS hold after RAS", t_cr - t_rf, K_CHR);
        t_rr = cyc; kind_at_rise = kind;
      end
      dq_in <= (!cas_n && !oe_n) ? rd_mem({row_m, col_m}) : 4'h0;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  logic [3:0] r;
  task automatic do_op(input logic [1:0] op, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    req = 1; we = op[0]; rmw = op[1]; addr = a; wdata = d; cur_addr = a;
    do @(negedge clk); while (!ack);
    r = rdata; req = 0;
    chk(kind == (op[1] ? 2 : int'(op[0])), "R10 cycle type", kind, op[1] ? 2 : int'(op[0]));
    @(negedge clk);
    chk(!ack, "R2 ack single clock", ack, 0);
  endtask

  localparam logic [31:0] VEC [0:10] = '{
    {2'd1, 22'h000001, 4'h5, 4'h0}, {2'd1, 22'h3FFFFF, 4'hA, 4'h0},
    {2'd0, 22'h000001, 4'h0, 4'h5}, {2'd0, 22'h3FFFFF, 4'h0, 4'hA},
    {2'd2, 22'h000001, 4'h3, 4'h5}, {2'd0, 22'h000001, 4'h0, 4'h3},
    {2'd1, 22'h000400, 4'hC, 4'h0}, {2'd0, 22'h000400, 4'h0, 4'hC},
    {2'd0, 22'h000000, 4'h0, 4'h0}, {2'd3, 22'h3FFFFF, 4'h6, 4'hA},
    {2'd0, 22'h3FFFFF, 4'h0, 4'h6}};

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && !dq_oe && !ack && !ref_done,
        "R1 reset pins", {ras_n, cas_n, we_n, oe_n, dq_oe, ack}, 6'h3C);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && !dq_oe, "R1 idle after reset",
        {ras_n, cas_n, we_n, oe_n}, 4'hF);

    for (int i = 0; i < 11; i++) begin
      do_op(VEC[i][31:30], VEC[i][29:8], VEC[i][7:4]);
      if (VEC[i][31:30] != 2'd1)
        chk(r == VEC[i][3:0], (VEC[i][31]) ? "R5 old word returned" : "R2 read data", r, VEC[i][3:0]);
    end

    begin
      int c0;
      c0 = cbr_cnt;
      @(negedge clk); ref_req = 1;
      do @(negedge clk); while (!ref_done);
      ref_req = 0;
      chk(cbr_cnt == c0 + 1, "R6 one refresh", cbr_cnt, c0 + 1);
      @(negedge clk);
      chk(!ref_done && !ack, "R6 ref_done single clock", ref_done, 0);
    end

    track = 1;
    fork
      do_op(2'd0, 22'h3FFFFF, 4'h0);
      begin
        ref_req = 1;
        do @(negedge clk); while (!ref_done);
        ref_req = 0;
      end
    join
    chk(first_cbr, "R8 refresh first", first_cbr, 1);
    chk(r == 4'h6, "R8 read after refresh", r, 6);

    begin
      int c0;
      c0 = cbr_cnt;
      fork
        do_op(2'd0, 22'h000400, 4'h0);
        begin
          do @(negedge clk); while (ras_n);
          ref_req = 1;
          do @(negedge clk); while (!ref_done);
          ref_req = 0;
        end
      join
      chk(r == 4'hC, "R8 read not cut by refresh", r, 12);
      chk(cbr_cnt == c0 + 1, "R8 refresh after cycle", cbr_cnt, c0 + 1);
    end

    repeat (20) @(negedge clk);
    summary();
  end
endmodule